// File: doc/BRIEF.md
# Busy-Status Read Path

This block builds the byte returned to a host when it reads a nonvolatile memory model. While the memory is idle, a read returns the stored array byte unchanged. While an internal programming cycle runs, the read byte carries two end-of-write indicators. The poll bit (bit 7) is the inverse of bit 7 of the byte most recently written. The toggle bit (bit 6) flips on every read made during the busy period. A host can watch either indicator and can start watching at any point in the cycle.

The memory core supplies the array byte for the requested address, the busy flag, and the value and address of the last byte written. The host raises a one-cycle read strobe. On that clock edge the formed byte is captured into the output register, and it stays there until the next strobe. The busy flag means the same thing whatever started the busy period: an accepted write and a rejected write, which starts the timer but stores nothing, produce identical polling reads. The poll bit is inverted only when the read address equals the last written address; a busy read of any other address shows that location's true bit 7. The remaining low bits always come from the array. The toggle state changes only on a busy read, never on a plain clock or an idle read.

Top module: `busy_rd_path`

## Requirements
- R1: On a read strobe with busy=1 and rd_addr equal to last_wr_addr, rd_data bit 7 on the next cycle equals the inverse of last_wr_data bit 7, whatever caused the busy period.
- R2: On a read strobe with busy=0, all eight bits of rd_data on the next cycle equal arr_data as it was at the strobe.
- R3: On a read strobe with busy=1, rd_data bit 6 is the inverse of bit 6 returned by the previous busy read.
- R4: The toggle state advances only on a read strobe with busy=1. Idle reads and clocks without a strobe leave it unchanged, so the next busy read continues the alternation.
- R5: On a read strobe with busy=1, rd_data bits 5..0 equal arr_data bits 5..0.
- R6: On a read strobe with busy=1 and rd_addr different from last_wr_addr, rd_data bit 7 equals arr_data bit 7.
- R7: rd_data holds its value in every cycle without a read strobe.
- R8: After reset, rd_data is 0x00 and the toggle state is 0, so the first busy read returns bit 6 = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_stb | input | 1 | One-cycle read strobe |
| rd_addr | input | ADDR_W | Address being read |
| arr_data | input | 8 | Array byte at rd_addr |
| busy | input | 1 | Programming cycle in progress |
| last_wr_data | input | 8 | Last byte written |
| last_wr_addr | input | ADDR_W | Address of last byte written |
| rd_data | output | 8 | Registered read byte |

## Verification
Idle reads with random array bytes show that true data passes through unchanged. Busy reads at the last written address and at other addresses separate the inverted poll bit from the true bit 7. Runs of busy reads mixed with idle reads and gaps without a strobe show that the toggle bit alternates only across busy reads. Random streams that flip busy and the strobe independently, compared against a bench model of the toggle state, catch any extra or missing toggle step.

// File: rtl/busy_rd_pkg.sv
package busy_rd_pkg;
  localparam int BYTE_W = 8;
  localparam int POLL_POS = 7;
  localparam int TGL_POS = 6;

  typedef logic [BYTE_W-1:0] byte_t;

  // Build the busy-time read byte from its parts.
  function automatic byte_t status_byte(input byte_t arr, input logic poll_hit,
                                        input logic lw7, input logic tgl);
    byte_t b;
    b = arr;
    if (poll_hit) b[POLL_POS] = ~lw7;
    b[TGL_POS] = tgl;
    return b;
  endfunction
endpackage

// File: rtl/busy_rd_toggle.sv
module busy_rd_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  output logic tgl_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tgl_q <= 1'b0;
    else if (adv) tgl_q <= ~tgl_q;
  end
endmodule

// File: rtl/busy_rd_addr_cmp.sv
module busy_rd_addr_cmp #(
  parameter int ADDR_W = 13,
  parameter bit MATCH_ADDR = 1'b1
) (
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic              hit
);
  generate
    if (MATCH_ADDR) begin : g_match
      assign hit = (rd_addr == wr_addr);
    end else begin : g_any
      logic unused_addr;
      assign unused_addr = ^{rd_addr, wr_addr};
      assign hit = 1'b1 | unused_addr;
    end
  endgenerate
endmodule

// File: rtl/busy_rd_form.sv
module busy_rd_form
  import busy_rd_pkg::*;
(
  input  byte_t arr_data,
  input  logic  busy,
  input  logic  poll_hit,
  input  logic  lw7,
  input  logic  tgl,
  output byte_t formed
);
  always_comb begin
    if (busy) formed = status_byte(arr_data, poll_hit, lw7, tgl);
    else      formed = arr_data;
  end
endmodule

// File: rtl/busy_rd_path.sv
module busy_rd_path
  import busy_rd_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter bit MATCH_ADDR = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_stb,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        arr_data,
  input  logic              busy,
  input  logic [7:0]        last_wr_data,
  input  logic [ADDR_W-1:0] last_wr_addr,
  output logic [7:0]        rd_data
);
  // Named internal events for the checker
  logic  rd_fire;     // any read accepted
  logic  busy_rd;     // read during programming
  logic  poll_hit;    // read address equals last written address
  logic  tgl_q;       // toggle state shown on the next busy read
  byte_t formed;

  assign rd_fire = rd_stb;
  assign busy_rd = rd_stb & busy;

  busy_rd_addr_cmp #(.ADDR_W(ADDR_W), .MATCH_ADDR(MATCH_ADDR)) u_cmp (
    .rd_addr(rd_addr), .wr_addr(last_wr_addr), .hit(poll_hit)
  );

  busy_rd_toggle u_tgl (
    .clk(clk), .rst_n(rst_n), .adv(busy_rd), .tgl_q(tgl_q)
  );

  busy_rd_form u_form (
    .arr_data(arr_data), .busy(busy), .poll_hit(poll_hit),
    .lw7(last_wr_data[POLL_POS]), .tgl(tgl_q), .formed(formed)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else if (rd_fire) rd_data <= formed;
  end
endmodule

// File: rtl/busy_rd_path_chk.sv
module busy_rd_path_chk #(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_stb,
  input logic              busy,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [ADDR_W-1:0] last_wr_addr,
  input logic [7:0]        arr_data,
  input logic [7:0]        last_wr_data,
  input logic [7:0]        rd_data,
  input logic              tgl_q
);
  AST_POLL_INV: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && busy && rd_addr == last_wr_addr) |=> rd_data[7] == ~$past(last_wr_data[7])); // R1
  AST_IDLE_TRUE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !busy) |=> rd_data == $past(arr_data)); // R2
  AST_TGL_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && busy) |=> tgl_q != $past(tgl_q)); // R3
  AST_TGL_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_stb && busy) |=> $stable(tgl_q)); // R4
  AST_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && busy) |=> rd_data[5:0] == $past(arr_data[5:0])); // R5
  AST_MISS_TRUE7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && busy && rd_addr != last_wr_addr) |=> rd_data[7] == $past(arr_data[7])); // R6
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(rd_data)); // R7
endmodule

bind busy_rd_path busy_rd_path_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .busy(busy), .rd_addr(rd_addr),
  .last_wr_addr(last_wr_addr), .arr_data(arr_data), .last_wr_data(last_wr_data),
  .rd_data(rd_data), .tgl_q(tgl_q)
);

// File: tb/sim_busy_rd_path.sv
module sim_busy_rd_path;
  localparam int AW = 13;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_stb = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0] arr_data = '0;
  logic busy = 1'b0;
  logic [7:0] last_wr_data = '0;
  logic [AW-1:0] last_wr_addr = '0;
  logic [7:0] rd_data;

  int n_chk = 0;
  int n_bad = 0;
  bit m_tgl = 1'b0;      // bench model of toggle state
  logic [7:0] m_out = 8'h00;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  busy_rd_path #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .rd_addr(rd_addr),
    .arr_data(arr_data), .busy(busy), .last_wr_data(last_wr_data),
    .last_wr_addr(last_wr_addr), .rd_data(rd_data)
  );

  // Expected byte, rebuilt bit by bit from the requirements
  function automatic logic [7:0] expect_byte(logic [7:0] arr, bit bz, bit same,
                                              logic [7:0] lw, bit t);
    logic [7:0] e;
    e[5:0] = arr[5:0];
    e[6] = bz ? t : arr[6];
    e[7] = (bz && same) ? !lw[7] : arr[7];
    return e;
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic do_read(logic [AW-1:0] a, logic [7:0] arr, bit bz,
                         logic [7:0] lw, logic [AW-1:0] lwa, string req);
    @(negedge clk);
    rd_addr = a; arr_data = arr; busy = bz; last_wr_data = lw; last_wr_addr = lwa;
    rd_stb = 1'b1;
    m_out = expect_byte(arr, bz, a == lwa, lw, m_tgl);
    if (bz) m_tgl = !m_tgl;
    @(negedge clk);
    rd_stb = 1'b0;
    check(req, rd_data, m_out);
  endtask

  task automatic idle_cycles(int n, bit bz);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      busy = bz; arr_data = 8'($urandom);
    end
    @(negedge clk);
    check("R7", rd_data, m_out);
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check("R8 reset", rd_data, 8'h00);
    rst_n = 1'b1;
    // R2 idle reads
    do_read(13'h0010, 8'hA5, 0, 8'h00, 13'h0010, "R2");
    do_read(13'h1FFF, 8'h5A, 0, 8'hFF, 13'h0000, "R2");
    // R8 first busy read gives bit6=0; R1 poll bit inverted
    do_read(13'h0123, 8'hFF, 1, 8'h80, 13'h0123, "R8 R1");
    do_read(13'h0123, 8'hFF, 1, 8'h80, 13'h0123, "R3 R1");
    do_read(13'h0123, 8'h00, 1, 8'h00, 13'h0123, "R3 R5");
    // R6 other address gives true bit 7
    do_read(13'h0200, 8'h80, 1, 8'h80, 13'h0123, "R6");
    do_read(13'h0200, 8'h3F, 1, 8'h00, 13'h0123, "R6 R5");
    // R4 idle read and quiet gap do not move toggle
    do_read(13'h0005, 8'h41, 0, 8'h00, 13'h0005, "R4 R2");
    idle_cycles(5, 1);
    do_read(13'h0005, 8'h00, 1, 8'hFF, 13'h0005, "R4 R3");
    // R1 rejected-write busy period: same polling behaviour
    do_read(13'h0777, 8'h12, 1, 8'h12, 13'h0777, "R1 rejected");
    // completion: true data returns
    do_read(13'h0777, 8'hC3, 0, 8'h12, 13'h0777, "R2 complete");
    idle_cycles(3, 0);
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [AW-1:0] la;
      logic [AW-1:0] a;
      la = AW'($urandom);
      a = ($urandom % 2) ? la : AW'($urandom);
      do_read(a, 8'($urandom), bit'($urandom % 2), 8'($urandom), la, "R1 R2 R3 R5 R6 random");
      if ($urandom % 4 == 0) idle_cycles(1 + $urandom % 3, bit'($urandom % 2));
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule